// File: doc/BRIEF.md
# Accumulator Single-Operand Unit

This unit applies one of eight single-operand operations to an 8-bit accumulator value and produces the new accumulator together with updated carry and half-carry (auxiliary-carry) flags. The operations are the four rotations (plain and through carry, in each direction), a nibble exchange, a bitwise inversion, a clear, and the decimal adjust that corrects a binary sum of two packed BCD bytes back into packed BCD.

The surrounding datapath presents the current accumulator and flags on its inputs, selects an operation with a 3-bit code and pulses a start strobe for one cycle. On the clock edge that samples the strobe the unit registers the result and flags; in the next cycle a one-cycle done pulse marks the result as valid. Between operations the registered outputs hold their values, so the unit can also serve as the accumulator holding register of a small processor core.

Top module: `acc_unary_unit`

## Requirements
- R1: A synchronous active-high reset sets the accumulator output to 0x00, clears the carry and half-carry outputs and holds done low.
- R2: Operation code 0 rotates left (bit 7 wraps into bit 0) and code 2 rotates right (bit 0 wraps into bit 7); both leave carry and half-carry unchanged.
- R3: Operation code 1 rotates left through carry: incoming bit 7 becomes the new carry and the incoming carry becomes bit 0; half-carry is unchanged.
- R4: Operation code 3 rotates right through carry: incoming bit 0 becomes the new carry and the incoming carry becomes bit 7; half-carry is unchanged.
- R5: Code 4 exchanges the upper and lower nibbles, code 6 inverts all eight bits and code 7 writes 0x00; all three leave carry and half-carry unchanged.
- R6: Code 5 (decimal adjust) adds 6 to the low nibble when that nibble exceeds 9 or the incoming half-carry is set; a carry out of the low nibble increments the high nibble, and a wrap of the high nibble from that increment sets carry.
- R7: In decimal adjust, after the low-nibble step the high nibble receives +6 when it exceeds 9 or carry (incoming or set by the low step) is set, and a wrap of it sets carry; an incoming carry is never cleared, and the half-carry output is always cleared.
- R8: Result and flags are registered on the rising edge that samples start high; done is high in exactly the following cycle; with start low the outputs keep their values and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that launches the selected operation |
| op | input | 3 | Operation code (0 rotl, 1 rotl via carry, 2 rotr, 3 rotr via carry, 4 swap, 5 decimal adjust, 6 invert, 7 clear) |
| acc_in | input | 8 | Current accumulator value |
| cy_in | input | 1 | Current carry flag |
| hc_in | input | 1 | Current half-carry flag |
| acc_out | output | 8 | Registered result accumulator |
| cy_out | output | 1 | Registered result carry |
| hc_out | output | 1 | Registered result half-carry |
| done | output | 1 | High for one cycle when a new result is on the outputs |

## Verification
The rotations are driven with values whose end bits differ from the incoming carry (0x81, 0x40, 0x01, 0x02 with carry both set and clear), which separates a plain rotate from one through carry and exposes a swapped direction. Decimal adjust is tried with a low nibble above 9, with the half-carry forcing a correction on a small nibble, with only the high nibble above 9, with an incoming carry on in-range digits, and with 0xFA, where the low correction ripples into a high-nibble wrap and then forces the second correction; these tell apart a missing propagation, a carry that is cleared instead of kept, and a half-carry that survives. Swap, invert and clear use asymmetric patterns with flags set, so a flag disturbance or a half-swap shows up, and idle cycles with changing inputs check that nothing moves without the strobe.

// File: rtl/acc_unary_pkg.sv
package acc_unary_pkg;

    localparam int ACC_W = 8;
    localparam int NIB_W = ACC_W / 2;
    localparam int OP_W  = 3;

    localparam logic [NIB_W-1:0] BCD_TOP = NIB_W'(9);
    localparam logic [NIB_W-1:0] BCD_FIX = NIB_W'(6);

    typedef enum logic [OP_W-1:0] {
        OP_ROTL    = 3'd0,
        OP_ROTL_CY = 3'd1,
        OP_ROTR    = 3'd2,
        OP_ROTR_CY = 3'd3,
        OP_SWAP    = 3'd4,
        OP_DECADJ  = 3'd5,
        OP_INVERT  = 3'd6,
        OP_CLEAR   = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             cy;
        logic             hc;
    } acc_state_t;

    // Widened nibble add so the carry out is visible in the top bit.
    function automatic logic [NIB_W:0] nib_add(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

endpackage

// File: rtl/acc_shift.sv
module acc_shift
    import acc_unary_pkg::*;
(
    input  acc_op_e    op,
    input  acc_state_t st_in,
    output acc_state_t st_out
);
    localparam int MSB = ACC_W - 1;

    always_comb begin
        st_out = st_in;
        unique case (op)
            OP_ROTL:    st_out.acc = {st_in.acc[MSB-1:0], st_in.acc[MSB]};
            OP_ROTR:    st_out.acc = {st_in.acc[0], st_in.acc[MSB:1]};
            OP_ROTL_CY: begin
                st_out.acc = {st_in.acc[MSB-1:0], st_in.cy};
                st_out.cy  = st_in.acc[MSB];
            end
            OP_ROTR_CY: begin
                st_out.acc = {st_in.cy, st_in.acc[MSB:1]};
                st_out.cy  = st_in.acc[0];
            end
            OP_SWAP:    st_out.acc = {st_in.acc[NIB_W-1:0], st_in.acc[ACC_W-1:NIB_W]};
            default:    st_out = st_in;
        endcase
    end
endmodule

// File: rtl/acc_decadj.sv
module acc_decadj
    import acc_unary_pkg::*;
(
    input  acc_state_t st_in,
    output acc_state_t st_out
);
    logic [NIB_W-1:0] lo_n, hi_n, hi_mid;
    logic [NIB_W:0]   lo_sum, hi_inc, hi_sum;
    logic             lo_fix, hi_fix, cy_mid;

    always_comb begin
        lo_n   = st_in.acc[NIB_W-1:0];
        hi_n   = st_in.acc[ACC_W-1:NIB_W];
        // low digit step
        lo_fix = (lo_n > BCD_TOP) || st_in.hc;
        lo_sum = lo_fix ? nib_add(lo_n, BCD_FIX) : {1'b0, lo_n};
        hi_inc = nib_add(hi_n, {{(NIB_W-1){1'b0}}, lo_sum[NIB_W]});
        hi_mid = hi_inc[NIB_W-1:0];
        cy_mid = st_in.cy | hi_inc[NIB_W];
        // high digit step
        hi_fix = (hi_mid > BCD_TOP) || cy_mid;
        hi_sum = hi_fix ? nib_add(hi_mid, BCD_FIX) : {1'b0, hi_mid};

        st_out.acc = {hi_sum[NIB_W-1:0], lo_sum[NIB_W-1:0]};
        st_out.cy  = cy_mid | hi_sum[NIB_W];
        st_out.hc  = 1'b0;
    end
endmodule

// File: rtl/acc_bitwise.sv
module acc_bitwise
    import acc_unary_pkg::*;
(
    input  acc_op_e    op,
    input  acc_state_t st_in,
    output acc_state_t st_out
);
    always_comb begin
        st_out = st_in;
        if (op == OP_INVERT)
            st_out.acc = ~st_in.acc;
        else if (op == OP_CLEAR)
            st_out.acc = '0;
    end
endmodule

// File: rtl/acc_unary_unit.sv
module acc_unary_unit
    import acc_unary_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OP_W-1:0]  op,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             cy_in,
    input  logic             hc_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             cy_out,
    output logic             hc_out,
    output logic             done
);
    acc_op_e    op_sel;
    acc_state_t cur_st, shift_st, adj_st, bit_st, next_st, held_st;
    logic       done_q;

    assign op_sel = acc_op_e'(op);
    assign cur_st = '{acc: acc_in, cy: cy_in, hc: hc_in};

    acc_shift   u_shift (.op(op_sel), .st_in(cur_st), .st_out(shift_st));
    acc_decadj  u_adj   (.st_in(cur_st), .st_out(adj_st));
    acc_bitwise u_bit   (.op(op_sel), .st_in(cur_st), .st_out(bit_st));

    always_comb begin
        unique case (op_sel)
            OP_DECADJ:            next_st = adj_st;
            OP_INVERT, OP_CLEAR:  next_st = bit_st;
            default:              next_st = shift_st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_st <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= start;
            if (start)
                held_st <= next_st;
        end
    end

    assign acc_out = held_st.acc;
    assign cy_out  = held_st.cy;
    assign hc_out  = held_st.hc;
    assign done    = done_q;
endmodule

// File: rtl/acc_unary_chk.sv
module acc_unary_chk
    import acc_unary_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [OP_W-1:0]  op,
    input logic [ACC_W-1:0] acc_in,
    input logic             cy_in,
    input logic             hc_in,
    input logic [ACC_W-1:0] acc_out,
    input logic             cy_out,
    input logic             hc_out,
    input logic             done
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !cy_out && !hc_out && !done)); // R1

    AST_PLAIN_ROT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (start && (op == 3'd0 || op == 3'd2)) |=>
        (cy_out == $past(cy_in) && hc_out == $past(hc_in))); // R2

    AST_ROTL_CY_MOVES: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd1) |=>
        (cy_out == $past(acc_in[ACC_W-1]) && acc_out[0] == $past(cy_in))); // R3

    AST_ROTR_CY_MOVES: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd3) |=>
        (cy_out == $past(acc_in[0]) && acc_out[ACC_W-1] == $past(cy_in))); // R4

    AST_WORD_OPS_KEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (start && (op == 3'd4 || op == 3'd6 || op == 3'd7)) |=>
        (cy_out == $past(cy_in) && hc_out == $past(hc_in))); // R5

    AST_DECADJ_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd5 && cy_in) |=> cy_out); // R7

    AST_DECADJ_CLEARS_HC: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd5) |=> !hc_out); // R7

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R8

    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done); // R8

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(acc_out) && $stable(cy_out) && $stable(hc_out))); // R8
endmodule

bind acc_unary_unit acc_unary_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .acc_in(acc_in), .cy_in(cy_in), .hc_in(hc_in),
    .acc_out(acc_out), .cy_out(cy_out), .hc_out(hc_out), .done(done)
);

// File: tb/acc_unary_unit_bench.sv
module acc_unary_unit_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [2:0] op;
    logic [7:0] acc_in;
    logic       cy_in, hc_in;
    logic [7:0] acc_out;
    logic       cy_out, hc_out, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_unary_unit u_acc_unary_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .acc_in(acc_in), .cy_in(cy_in), .hc_in(hc_in),
        .acc_out(acc_out), .cy_out(cy_out), .hc_out(hc_out), .done(done)
    );

    // op, a, cy, hc, expected a, expected cy, expected hc
    localparam int NV = 22;
    localparam logic [22:0] VEC [NV] = '{
        {3'd0, 8'h81, 1'b0, 1'b1, 8'h03, 1'b0, 1'b1},   // R2 rotl wrap
        {3'd0, 8'h40, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},   // R2
        {3'd2, 8'h01, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},   // R2 rotr wrap
        {3'd2, 8'h80, 1'b0, 1'b1, 8'h40, 1'b0, 1'b1},   // R2
        {3'd1, 8'h81, 1'b0, 1'b0, 8'h02, 1'b1, 1'b0},   // R3
        {3'd1, 8'h40, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1},   // R3
        {3'd3, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},   // R4
        {3'd3, 8'h02, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1},   // R4
        {3'd4, 8'h3C, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1},   // R5 swap
        {3'd4, 8'h1F, 1'b0, 1'b0, 8'hF1, 1'b0, 1'b0},   // R5 swap
        {3'd6, 8'h5A, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},   // R5 invert
        {3'd6, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1},   // R5 invert
        {3'd7, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},   // R5 clear
        {3'd5, 8'h0A, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0},   // R6 low > 9
        {3'd5, 8'h12, 1'b0, 1'b1, 8'h18, 1'b0, 1'b0},   // R6 half-carry forces fix
        {3'd5, 8'h45, 1'b0, 1'b1, 8'h4B, 1'b0, 1'b0},   // R6
        {3'd5, 8'h45, 1'b0, 1'b0, 8'h45, 1'b0, 1'b0},   // R6 no fix
        {3'd5, 8'h9A, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},   // R6 ripple then high wrap
        {3'd5, 8'hFA, 1'b0, 1'b0, 8'h60, 1'b1, 1'b0},   // R6 ripple wraps high, second fix
        {3'd5, 8'hA0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},   // R7 high > 9
        {3'd5, 8'h23, 1'b1, 1'b0, 8'h83, 1'b1, 1'b0},   // R7 carry kept and forces fix
        {3'd5, 8'h99, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0}    // R7 both fixes, carry kept
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [7:0] a,
                          input logic c, input logic h);
        @(negedge clk);
        op = o; acc_in = a; cy_in = c; hc_in = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; acc_in = 8'hA7; cy_in = 1'b1; hc_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset acc", acc_out, 8'h00);
        check("R1 reset flags/done", {5'd0, cy_out, hc_out, done}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            run_op(v[22:20], v[19:12], v[11], v[10]);
            check($sformatf("R%0s vec %0d acc", "x", i), acc_out, v[9:2]);
            check($sformatf("vec %0d flags (R2-R7 set)", i), {6'd0, cy_out, hc_out}, {6'd0, v[1], v[0]});
            check("R8 done after start", {7'd0, done}, 8'd1);
        end

        // R8: idle cycle with changed inputs, outputs hold, done low
        run_op(3'd6, 8'h0F, 1'b0, 1'b1);
        check("R5 invert before hold", acc_out, 8'hF0);
        op = 3'd7; acc_in = 8'h33; cy_in = 1'b1; hc_in = 1'b0;
        @(negedge clk);
        check("R8 hold acc", acc_out, 8'hF0);
        check("R8 hold flags", {6'd0, cy_out, hc_out}, 8'h01);
        check("R8 done one cycle", {7'd0, done}, 8'd0);
        @(negedge clk);
        check("R8 still held", acc_out, 8'hF0);

        // R8: back-to-back strobes, each result lands the next cycle
        @(negedge clk);
        op = 3'd4; acc_in = 8'h12; cy_in = 1'b0; hc_in = 1'b0; start = 1'b1;
        @(negedge clk);
        check("R8 first of pair", acc_out, 8'h21);
        op = 3'd0; acc_in = 8'hC0;
        @(negedge clk);
        start = 1'b0;
        check("R8 second of pair", acc_out, 8'h81);
        check("R8 done held over pair", {7'd0, done}, 8'd1);

        // R1: reset in mid run clears registered state
        run_op(3'd6, 8'h00, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset acc", acc_out, 8'h00);
        check("R1 mid-run reset flags", {6'd0, cy_out, hc_out}, 8'h00);

        // R6/R7 corner: all-ones digits with no flags
        run_op(3'd5, 8'hFF, 1'b0, 1'b0);
        check("R6 decadj FF acc", acc_out, 8'h65);
        check("R7 decadj FF carry", {6'd0, cy_out, hc_out}, 8'h02);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule